// File: doc/BRIEF.md
# Inline-Tag Receive DMA Channel

This channel moves data from a 32-bit inbound FIFO into memory as 128-bit quadwords. The producer interleaves control tags with payload in the same FIFO stream. Each tag takes two FIFO words and gives the number of quadwords that follow and the memory address they go to. The channel pops the payload four words at a time, packs each group into one quadword and hands it to memory over a valid/ready write port. The address steps by 16 bytes for every accepted write.

Software drives a small register port. It selects one of four registers: control, destination address, quadword count and tag address. A separate global enable input gates every launch. When a segment ends with its count at zero, and both the control tag-interrupt-enable bit and the tag's own interrupt flag were set, the channel stops and raises a one-cycle completion pulse. Otherwise it goes on to read the next tag from the FIFO. The channel pops only once the FIFO holds a whole tag or a whole quadword, so a short FIFO leaves it waiting with nothing consumed.

Top module: `inline_tag_dma`

## Requirements
- R1: After reset the control, address, count and tag-address outputs are zero, and fifoPop, memValid and donePulse are low.
- R2: A register write (regSel 0 = control, 1 = destination address, 2 = count, 3 = tag address) is stored on the next clock edge. A count write keeps only regWdata[15:0].
- R3: A control write launches the channel only when regWdata[0] (start) is 1 and globalEnable is 1. Any other control write leaves control bit 0 reading 0, and the channel idles and pops nothing.
- R4: A tag is read only when fifoLevel is at least 2, and the first popped word is tag bits [31:0]. The count comes from tag[15:0], control bits [31:16] take tag[31:16], and the destination address comes from tag[62:32] (second word bits [30:0]). The tag address grows by 16.
- R5: A quadword is gathered only when fifoLevel is at least 4. The first popped word becomes memData[31:0] and the fourth becomes memData[127:96].
- R6: memValid stays high, with memAddr and memData unchanged, until memReady is seen. The count decrements by one only on an accepted write.
- R7: Each accepted write advances the destination address by 16.
- R8: If the count is non-zero at launch, payload is moved to the current destination address before any tag is read.
- R9: When the count is zero, and control bit 1 (tag interrupt enable) and tag bit 31 (tag interrupt) were both set, control bit 0 clears and donePulse is high for one cycle. Otherwise the channel reads the next tag.
- R10: fifoPop is never high while fifoLevel is zero. While the FIFO holds too few words, no word is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEnable | input | 1 | Global DMA enable; required to launch |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 ctrl, 1 addr, 2 count, 3 tag address) |
| regWdata | input | 32 | Register write data |
| ctrlOut | output | 32 | Control register |
| addrOut | output | AW | Destination address |
| countOut | output | CW | Remaining quadword count |
| tagAddrOut | output | 32 | Tag address |
| fifoLevel | input | LW | Words currently held in the inbound FIFO |
| fifoData | input | 32 | FIFO head word |
| fifoPop | output | 1 | Pop the head word at this edge |
| memValid | output | 1 | Quadword write request |
| memReady | input | 1 | Memory accepts the write |
| memAddr | output | AW | Write byte address |
| memData | output | 128 | Write data |
| donePulse | output | 1 | One-cycle completion flag |

## Verification
The assertions watch several rules on every cycle: no pop from an empty FIFO, a stalled write request that holds steady, count and address stepping together on each accepted write, the truncated count write, a refused launch, and a completion pulse that never lasts two cycles. Other behaviour depends on the stream as a whole, and only the bench scenarios show it. These are the order of words inside a packed quadword, the split of tag fields, waiting on a partly filled FIFO, payload ahead of the first tag when a count is preloaded, and the choice between finishing and reading a further tag.

// File: rtl/itdma_pkg.sv
package itdma_pkg;
  parameter int DW = 32;
  parameter int QW = 128;
  localparam int WORDS_PER_QW = QW / DW;
  localparam int TAG_WORDS = 64 / DW;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_TAGADDR = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_WAIT_TAG, ST_TAG_HI, ST_WAIT_QW, ST_QW_FILL, ST_WRITE
  } dmaState_e;

  typedef struct packed {
    logic launch;
    logic tagLo;
    logic tagHi;
    logic dataPop;
    logic qwAccept;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/itdma_ctrl.sv
module itdma_ctrl
  import itdma_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic          startBit,
  input  logic          globalEnable,
  input  logic [LW-1:0] fifoLevel,
  input  logic          memReady,
  input  logic          countZero,
  input  logic          irqArm,
  output strobe_t       s,
  output logic          fifoPop,
  output logic          memValid,
  output logic          donePulse
);
  localparam int IW = $clog2(WORDS_PER_QW);

  dmaState_e state, nextState;
  logic [IW-1:0] wordIdx;
  logic ctrlWrite;

  assign ctrlWrite = regWe && (regSel == SEL_CTRL);

  always_comb begin
    s = '0;
    fifoPop = 1'b0;
    memValid = 1'b0;
    nextState = state;
    case (state)
      ST_DECIDE: begin
        if (!countZero) nextState = ST_WAIT_QW;
        else if (irqArm) begin
          s.finish = 1'b1;
          nextState = ST_IDLE;
        end else nextState = ST_WAIT_TAG;
      end
      ST_WAIT_TAG: if (fifoLevel >= LW'(TAG_WORDS)) begin
        fifoPop = 1'b1;
        s.tagLo = 1'b1;
        nextState = ST_TAG_HI;
      end
      ST_TAG_HI: begin
        fifoPop = 1'b1;
        s.tagHi = 1'b1;
        nextState = ST_DECIDE;
      end
      ST_WAIT_QW: if (fifoLevel >= LW'(WORDS_PER_QW)) begin
        fifoPop = 1'b1;
        s.dataPop = 1'b1;
        nextState = ST_QW_FILL;
      end
      ST_QW_FILL: begin
        fifoPop = 1'b1;
        s.dataPop = 1'b1;
        if (wordIdx == IW'(WORDS_PER_QW - 1)) nextState = ST_WRITE;
      end
      ST_WRITE: begin
        memValid = 1'b1;
        if (memReady) begin
          s.qwAccept = 1'b1;
          nextState = ST_DECIDE;
        end
      end
      default: nextState = state;
    endcase
    if (ctrlWrite) begin
      s.launch = startBit && globalEnable;
      nextState = (startBit && globalEnable) ? ST_DECIDE : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wordIdx <= '0;
      donePulse <= 1'b0;
    end else begin
      state <= nextState;
      donePulse <= s.finish;
      if (state == ST_WAIT_QW) wordIdx <= IW'(1);
      else if (state == ST_QW_FILL) wordIdx <= wordIdx + 1'b1;
    end
  end

  // R10
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> fifoLevel != '0);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
endmodule

// File: rtl/itdma_dpath.sv
module itdma_dpath
  import itdma_pkg::*;
#(
  parameter int AW = 31,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic [DW-1:0] regWdata,
  input  logic          globalEnable,
  input  logic [DW-1:0] fifoData,
  input  strobe_t       s,
  output logic [DW-1:0] ctrlReg,
  output logic [AW-1:0] dstAddr,
  output logic [CW-1:0] qwCount,
  output logic [DW-1:0] tagAddr,
  output logic [QW-1:0] qwBuf,
  output logic          irqArm,
  output logic          countZero
);
  localparam int HALF = DW / 2;

  assign countZero = (qwCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      dstAddr <= '0;
      qwCount <= '0;
      tagAddr <= '0;
      qwBuf <= '0;
      irqArm <= 1'b0;
    end else begin
      if (regWe) begin
        case (regSel)
          SEL_CTRL: ctrlReg <= {regWdata[DW-1:1], regWdata[0] & globalEnable};
          SEL_ADDR: dstAddr <= regWdata[AW-1:0];
          SEL_COUNT: qwCount <= regWdata[CW-1:0];
          default: tagAddr <= regWdata;
        endcase
      end
      if (s.tagLo) begin
        qwCount <= fifoData[CW-1:0];
        ctrlReg[DW-1:HALF] <= fifoData[DW-1:HALF];
        tagAddr <= tagAddr + DW'(16);
        irqArm <= ctrlReg[1] & fifoData[DW-1];
      end
      if (s.tagHi) dstAddr <= fifoData[AW-1:0];
      if (s.dataPop) qwBuf <= {fifoData, qwBuf[QW-1:DW]};
      if (s.qwAccept) begin
        qwCount <= qwCount - 1'b1;
        dstAddr <= dstAddr + AW'(16);
      end
      if (s.launch) irqArm <= 1'b0;
      if (s.finish) begin
        ctrlReg[0] <= 1'b0;
        irqArm <= 1'b0;
      end
    end
  end

  // R2
  count_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel == SEL_COUNT && !s.tagLo && !s.qwAccept)
      |=> qwCount == $past(regWdata[CW-1:0]));

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel == SEL_CTRL && !globalEnable) |=> !ctrlReg[0]);

  // R6 R7
  accept_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s.qwAccept && !regWe)
      |=> (qwCount == $past(qwCount) - 1'b1) && (dstAddr == $past(dstAddr) + AW'(16)));
endmodule

// File: rtl/inline_tag_dma.sv
module inline_tag_dma
  import itdma_pkg::*;
#(
  parameter int AW = 31,
  parameter int CW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          globalEnable,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic [31:0]   regWdata,
  output logic [31:0]   ctrlOut,
  output logic [AW-1:0] addrOut,
  output logic [CW-1:0] countOut,
  output logic [31:0]   tagAddrOut,
  input  logic [LW-1:0] fifoLevel,
  input  logic [31:0]   fifoData,
  output logic          fifoPop,
  output logic          memValid,
  input  logic          memReady,
  output logic [AW-1:0] memAddr,
  output logic [127:0]  memData,
  output logic          donePulse
);
  strobe_t s;
  logic irqArm, countZero;

  itdma_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .startBit(regWdata[0]), .globalEnable(globalEnable),
    .fifoLevel(fifoLevel), .memReady(memReady), .countZero(countZero),
    .irqArm(irqArm), .s(s), .fifoPop(fifoPop), .memValid(memValid),
    .donePulse(donePulse)
  );

  itdma_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .globalEnable(globalEnable), .fifoData(fifoData),
    .s(s), .ctrlReg(ctrlOut), .dstAddr(addrOut), .qwCount(countOut),
    .tagAddr(tagAddrOut), .qwBuf(memData), .irqArm(irqArm),
    .countZero(countZero)
  );

  assign memAddr = addrOut;

  // R6
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady && !regWe)
      |=> memValid && $stable(memAddr) && $stable(memData));
endmodule

// File: tb/test_inline_tag_dma.sv
module test_inline_tag_dma;
  localparam int AW = 31;
  localparam int CW = 16;
  localparam int LW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, globalEnable = 1'b0, regWe = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] ctrlOut, tagAddrOut;
  logic [AW-1:0] addrOut, memAddr;
  logic [CW-1:0] countOut;
  logic [LW-1:0] fifoLevel = '0;
  logic [31:0] fifoData = '0;
  logic fifoPop, memValid, donePulse;
  logic memReady = 1'b0;
  logic [127:0] memData;

  inline_tag_dma i_inline_tag_dma (
    .clk(clk), .rstN(rstN), .globalEnable(globalEnable), .regWe(regWe),
    .regSel(regSel), .regWdata(regWdata), .ctrlOut(ctrlOut), .addrOut(addrOut),
    .countOut(countOut), .tagAddrOut(tagAddrOut), .fifoLevel(fifoLevel),
    .fifoData(fifoData), .fifoPop(fifoPop), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .donePulse(donePulse)
  );

  int checks = 0, errors = 0, cyc = 0, doneCount = 0;
  logic [31:0] fq[$];
  logic [AW-1:0] expAddrQ[$];
  logic [127:0] expDataQ[$];
  logic pendPop = 1'b0, acceptPrev = 1'b0, holdPrev = 1'b0, donePrev = 1'b0;
  logic [CW-1:0] prevCount;
  logic [AW-1:0] prevAddr;
  logic [127:0] holdData;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // FIFO model, write sink and scoreboard monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pendPop && fq.size() > 0) fq.delete(0);
    fifoLevel = LW'(fq.size());
    fifoData = (fq.size() > 0) ? fq[0] : 32'h0;
    memReady = (cyc % 3) != 1;
    #1;
    pendPop = fifoPop;
    if (rstN) begin
      if (acceptPrev) begin
        chk(countOut == prevCount - 1'b1, "R6 count step", countOut, prevCount - 1'b1);
        chk(addrOut == prevAddr + AW'(16), "R7 address step", addrOut, prevAddr + AW'(16));
      end
      if (holdPrev) begin
        chk(memValid && memAddr == prevAddr && memData == holdData, "R6 hold",
            memData, holdData);
      end
      acceptPrev = memValid && memReady;
      holdPrev = memValid && !memReady;
      prevCount = countOut;
      prevAddr = addrOut;
      holdData = memData;
      if (memValid && memReady) begin
        if (expAddrQ.size() == 0) chk(1'b0, "R5 unexpected write", memData, 0);
        else begin
          chk(memAddr == expAddrQ[0], "R7 write address", memAddr, expAddrQ[0]);
          chk(memData == expDataQ[0], "R5 write data", memData, expDataQ[0]);
          expAddrQ.delete(0);
          expDataQ.delete(0);
        end
      end
      if (donePulse) begin
        doneCount++;
        if (donePrev) chk(1'b0, "R9 pulse width", 2, 1);
      end
      donePrev = donePulse;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    summary();
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #2;
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(posedge clk); #2;
    regWe = 1'b0;
  endtask

  task automatic pushTag(input logic [15:0] upper, input logic [15:0] cnt,
                         input logic [30:0] addr);
    fq.push_back({upper, cnt});
    fq.push_back({1'b0, addr});
  endtask

  task automatic expectQw(input logic [AW-1:0] addr, input logic [31:0] base);
    expAddrQ.push_back(addr);
    expDataQ.push_back({base + 32'd3, base + 32'd2, base + 32'd1, base});
  endtask

  task automatic pushQw(input logic [AW-1:0] addr, input logic [31:0] base);
    expectQw(addr, base);
    for (int i = 0; i < 4; i++) fq.push_back(base + 32'(i));
  endtask

  task automatic waitDone(input string req);
    int start = doneCount;
    int n = 0;
    while (doneCount == start && n < 3000) begin
      @(posedge clk);
      n++;
    end
    #2;
    chk(doneCount == start + 1, req, doneCount, start + 1);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    chk(ctrlOut == 0 && addrOut == 0 && countOut == 0 && tagAddrOut == 0,
        "R1 registers", {ctrlOut, addrOut, countOut, tagAddrOut}, 0);
    chk(!fifoPop && !memValid && !donePulse, "R1 strobes",
        {fifoPop, memValid, donePulse}, 0);
    rstN = 1'b1;
    idle(2);

    // R2 register writes
    wrReg(2'd2, 32'h0001_2345);
    chk(countOut == 16'h2345, "R2 count truncation", countOut, 16'h2345);
    wrReg(2'd1, 32'h0000_0770);
    chk(addrOut == 31'h770, "R2 address write", addrOut, 31'h770);
    wrReg(2'd3, 32'h0000_0100);
    chk(tagAddrOut == 32'h100, "R2 tag address write", tagAddrOut, 32'h100);

    // R3 launch refused without global enable
    globalEnable = 1'b0;
    wrReg(2'd0, 32'h3);
    fq.push_back(32'h1); fq.push_back(32'h2);
    idle(6);
    chk(ctrlOut[0] == 1'b0, "R3 start bit refused", ctrlOut[0], 0);
    chk(fq.size() == 2, "R3 no pop while idle", fq.size(), 2);
    fq.delete();
    idle(2);

    // Chain with two tags, last one requests completion
    globalEnable = 1'b1;
    wrReg(2'd2, 32'h0);
    wrReg(2'd0, 32'h3);
    fq.push_back({16'h25C3, 16'd2});
    idle(6);
    chk(fq.size() == 1, "R4 half tag waits", fq.size(), 1);
    chk(countOut == 0, "R10 no partial tag", countOut, 0);
    fq.push_back(32'h0000_1000);
    idle(6);
    chk(fq.size() == 0, "R4 tag consumed", fq.size(), 0);
    chk(countOut == 16'd2, "R4 count field", countOut, 2);
    chk(addrOut == 31'h1000, "R4 address field", addrOut, 31'h1000);
    chk(tagAddrOut == 32'h110, "R4 tag address step", tagAddrOut, 32'h110);
    chk(ctrlOut[31:16] == 16'h25C3, "R4 upper control bits", ctrlOut[31:16], 16'h25C3);
    expectQw(31'h1000, 32'hA0);
    for (int i = 0; i < 3; i++) fq.push_back(32'hA0 + 32'(i));
    idle(8);
    chk(fq.size() == 3, "R10 three words held", fq.size(), 3);
    chk(!memValid, "R5 no write before four words", memValid, 0);
    fq.push_back(32'hA3);
    pushQw(31'h1010, 32'hB0);
    pushTag(16'h9234, 16'd1, 31'h2000);
    pushQw(31'h2000, 32'hC0);
    waitDone("R9 completion pulse");
    idle(2);
    chk(ctrlOut[0] == 1'b0, "R9 start cleared", ctrlOut[0], 0);
    chk(ctrlOut[31:16] == 16'h9234, "R4 second tag upper bits", ctrlOut[31:16], 16'h9234);
    chk(addrOut == 31'h2010 && countOut == 0, "R7 final address", addrOut, 31'h2010);
    chk(tagAddrOut == 32'h120, "R4 tag address after two tags", tagAddrOut, 32'h120);
    chk(expAddrQ.size() == 0, "R5 all writes seen", expAddrQ.size(), 0);

    // R9 tag interrupt flag without enable: keeps fetching tags
    wrReg(2'd0, 32'h1);
    pushTag(16'h8001, 16'd1, 31'h4000);
    pushQw(31'h4000, 32'hD0);
    idle(40);
    chk(ctrlOut[0] == 1'b1, "R9 no finish without enable", ctrlOut[0], 1);
    chk(doneCount == 1, "R9 no pulse without enable", doneCount, 1);
    chk(fq.size() == 0 && expAddrQ.size() == 0, "R5 segment written", fq.size(), 0);
    wrReg(2'd0, 32'h0);
    idle(2);
    chk(ctrlOut[0] == 1'b0, "R3 control write stops", ctrlOut[0], 0);

    // R8 preloaded count moves payload before the first tag
    wrReg(2'd2, 32'h1);
    wrReg(2'd1, 32'h3000);
    wrReg(2'd0, 32'h3);
    pushQw(31'h3000, 32'hE0);
    pushTag(16'h8000, 16'd0, 31'h5000);
    waitDone("R8 preload completes");
    idle(2);
    chk(addrOut == 31'h5000 && countOut == 0, "R8 tag after payload", addrOut, 31'h5000);
    chk(expAddrQ.size() == 0, "R8 payload written first", expAddrQ.size(), 0);

    idle(5);
    summary();
  end
endmodule